// File: doc/BRIEF.md
# Word-addressed instruction fetch unit

This block owns the program counter of a processor whose instructions are all 32 bits wide and aligned to four bytes. Since an instruction address always ends in two zero bits, only the 30-bit word index is kept in a register. The byte address sent to the instruction memory is that index with two zero bits appended.

On every rising clock edge the block moves to the next instruction. It has three ways to form the next address. It can step forward by one word. It can take a PC-relative branch, which is taken when the branch select is high and the ALU zero flag reports equal operands. It can take a jump that keeps the top four address bits of the current PC and replaces the rest with a 26-bit target. The sequential step and the branch target come out of one adder with a carry-in of one. A parameter can select a faster variant with two adders instead.

The memory, the equality test and the instruction decoder are outside this block. The block receives the low 26 bits of the fetched word, the branch and jump selects from the decoder, and the zero flag from the ALU. A synchronous, active-high reset loads a start address set by a parameter.

Top module: `ifu_next_pc`

## Requirements
- R1: The two low bits of `imem_addr` are always 0, and `imem_addr[31:2]` is the stored word index.
- R2: While `rst` is 1 at a rising edge, `imem_addr` becomes `RESET_ADDR` (default 0x0000_0040), whatever the values of the select inputs.
- R3: When `jump_en` is 0 and the branch is not taken, `imem_addr` advances by 4 at each rising edge, wrapping from 0xFFFF_FFFC to 0.
- R4: When `branch_en` and `alu_zero` are both 1 and `jump_en` is 0, `imem_addr` becomes old `imem_addr` + 4 + 4 × sign-extended `fetch_field[15:0]`, modulo 2^32.
- R5: When only one of `branch_en` and `alu_zero` is 1, and `jump_en` is 0, the address takes the plain +4 step.
- R6: When `jump_en` is 1, the new `imem_addr` is {old `imem_addr[31:28]`, `fetch_field[25:0]`, 2'b00}.
- R7: When `jump_en` is 1 and a branch would also be taken, the jump result of R6 wins.
- R8: The four region bits of a jump come from the current address, not from the address incremented by 4. For example, a jump issued at 0x0FFF_FFFC with target 0x123 lands at 0x0000_048C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset to `RESET_ADDR` |
| branch_en | input | 1 | The decoded instruction is a conditional branch |
| jump_en | input | 1 | The decoded instruction is a jump |
| alu_zero | input | 1 | ALU zero flag; 1 when the branch operands are equal |
| fetch_field | input | 26 | Low 26 bits of the fetched instruction: jump target, with the 16-bit branch offset in [15:0] |
| imem_addr | output | 32 | Byte address of the current instruction, held in a register |

## Verification
The bench goes after wrap-around at both ends of the address space. A backward branch from address 0 must land on 0xFFFF_FFFC, and a step from there must return to 0; an adder of the wrong width or a mishandled carry would land elsewhere. It tests offsets 0x7FFF and 0x8000, where a zero-extended or unshifted immediate produces targets that are far off. It issues a jump from 0x0FFF_FFFC, where taking the region bits from the incremented PC would move the target into region 1. It also drives every combination of the three select inputs, so a branch gated on only one of its two conditions, or a branch that beats a jump, shows up as a wrong address.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

  // Source of the next program counter value
  typedef enum logic [1:0] {
    NPC_SEQ    = 2'd0,
    NPC_BRANCH = 2'd1,
    NPC_JUMP   = 2'd2
  } npc_src_e;

endpackage

// File: rtl/ifu_pc_reg.sv
// Word program counter with synchronous active-high reset.
module ifu_pc_reg #(
  parameter int PCW = 30,
  parameter logic [PCW-1:0] RESET_WORD = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [PCW-1:0] pc_d,
  output logic [PCW-1:0] pc_q
);

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_WORD;
    else     pc_q <= pc_d;
  end

endmodule

// File: rtl/ifu_step_adder.sv
// Sequential / branch target generator working on word indices.
// FAST_NEXT = 0: one adder, carry-in one, operand muxed before the add.
// FAST_NEXT = 1: incrementer plus offset adder, result muxed after the add.
module ifu_step_adder #(
  parameter int PCW       = 30,
  parameter int IMM_W     = 16,
  parameter bit FAST_NEXT = 1'b0
) (
  input  logic [PCW-1:0]   pc_word,
  input  logic [IMM_W-1:0] offset,
  input  logic             take_branch,
  output logic [PCW-1:0]   next_word
);

  localparam int EXT_W = PCW - IMM_W;

  logic [PCW-1:0] offset_ext;
  assign offset_ext = {{EXT_W{offset[IMM_W-1]}}, offset};

  generate
    if (FAST_NEXT) begin : g_fast
      logic [PCW-1:0] seq_word;
      logic [PCW-1:0] br_word;
      assign seq_word  = pc_word + PCW'(1);
      assign br_word   = seq_word + offset_ext;
      assign next_word = take_branch ? br_word : seq_word;
    end else begin : g_shared
      logic [PCW-1:0] addend;
      assign addend    = take_branch ? offset_ext : '0;
      assign next_word = pc_word + addend + PCW'(1);
    end
  endgenerate

endmodule

// File: rtl/ifu_jump_former.sv
// Pseudo-absolute jump: current region bits above the target field.
module ifu_jump_former #(
  parameter int PCW   = 30,
  parameter int TGT_W = 26
) (
  input  logic [PCW-TGT_W-1:0] region,
  input  logic [TGT_W-1:0]     target,
  output logic [PCW-1:0]       jump_word
);

  assign jump_word = {region, target};

endmodule

// File: rtl/ifu_next_pc.sv
module ifu_next_pc #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int TGT_W  = 26,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_0040,
  parameter bit FAST_NEXT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              branch_en,
  input  logic              jump_en,
  input  logic              alu_zero,
  input  logic [TGT_W-1:0]  fetch_field,
  output logic [ADDR_W-1:0] imem_addr
);

  localparam int PCW      = ADDR_W - 2;
  localparam int REGION_W = PCW - TGT_W;
  localparam logic [PCW-1:0] RESET_WORD = RESET_ADDR[ADDR_W-1:2];
  localparam logic [ADDR_W-1:0] STEP_BYTES = ADDR_W'(4);

  logic [PCW-1:0] pc_q;
  logic [PCW-1:0] pc_d;
  logic [PCW-1:0] step_word;
  logic [PCW-1:0] jump_word;
  logic           take_branch;
  ifu_pkg::npc_src_e src;

  assign take_branch = branch_en & alu_zero;

  always_comb begin
    if (jump_en)          src = ifu_pkg::NPC_JUMP;
    else if (take_branch) src = ifu_pkg::NPC_BRANCH;
    else                  src = ifu_pkg::NPC_SEQ;
  end

  ifu_step_adder #(
    .PCW(PCW), .IMM_W(IMM_W), .FAST_NEXT(FAST_NEXT)
  ) u_step (
    .pc_word(pc_q),
    .offset(fetch_field[IMM_W-1:0]),
    .take_branch(take_branch),
    .next_word(step_word)
  );

  ifu_jump_former #(.PCW(PCW), .TGT_W(TGT_W)) u_jump (
    .region(pc_q[PCW-1 -: REGION_W]),
    .target(fetch_field),
    .jump_word(jump_word)
  );

  always_comb begin
    case (src)
      ifu_pkg::NPC_JUMP: pc_d = jump_word;
      default:           pc_d = step_word;
    endcase
  end

  ifu_pc_reg #(.PCW(PCW), .RESET_WORD(RESET_WORD)) u_pc (
    .clk(clk), .rst(rst), .pc_d(pc_d), .pc_q(pc_q)
  );

  assign imem_addr = {pc_q, 2'b00};

  // Byte-level view of the branch offset, used only by the checks below
  logic [ADDR_W-1:0] br_off_bytes;
  assign br_off_bytes = {{(ADDR_W-IMM_W-2){fetch_field[IMM_W-1]}},
                         fetch_field[IMM_W-1:0], 2'b00};

  assert_reset_load_R2: assert property (@(posedge clk)
    rst |=> imem_addr == RESET_ADDR);

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!jump_en && !(branch_en && alu_zero)) |=>
      imem_addr == $past(imem_addr) + STEP_BYTES);

  assert_branch_taken_R4: assert property (@(posedge clk) disable iff (rst)
    (!jump_en && branch_en && alu_zero) |=>
      imem_addr == $past(imem_addr) + STEP_BYTES + $past(br_off_bytes));

  assert_half_cond_R5: assert property (@(posedge clk) disable iff (rst)
    (!jump_en && (branch_en ^ alu_zero)) |=>
      imem_addr == $past(imem_addr) + STEP_BYTES);

  assert_jump_target_R6: assert property (@(posedge clk) disable iff (rst)
    jump_en |=> imem_addr[TGT_W+1:2] == $past(fetch_field));

  assert_jump_first_R7: assert property (@(posedge clk) disable iff (rst)
    (jump_en && branch_en && alu_zero) |=>
      imem_addr[TGT_W+1:0] == {$past(fetch_field), 2'b00});

  assert_jump_region_R8: assert property (@(posedge clk) disable iff (rst)
    jump_en |=> imem_addr[ADDR_W-1:TGT_W+2] == $past(imem_addr[ADDR_W-1:TGT_W+2]));

endmodule

// File: tb/sim_ifu_next_pc.sv
module sim_ifu_next_pc;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_ADDR = 32'h0000_0040;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        branch_en = 1'b0;
  logic        jump_en = 1'b0;
  logic        alu_zero = 1'b0;
  logic [25:0] fetch_field = '0;
  logic [31:0] imem_addr;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_addr = RST_ADDR;
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifu_next_pc u0 (
    .clk(clk), .rst(rst), .branch_en(branch_en), .jump_en(jump_en),
    .alu_zero(alu_zero), .fetch_field(fetch_field), .imem_addr(imem_addr)
  );

  function automatic logic [31:0] model(input logic [31:0] cur, input logic r,
      input logic b, input logic j, input logic z, input logic [25:0] f);
    logic [31:0] off;
    off = {{14{f[15]}}, f[15:0], 2'b00};
    if (r)           return RST_ADDR;
    else if (j)      return {cur[31:28], f, 2'b00};
    else if (b && z) return cur + 32'd4 + off;
    else             return cur + 32'd4;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic b, input logic j, input logic z,
                      input logic [25:0] f, input string req);
    @(negedge clk);
    rst = r; branch_en = b; jump_en = j; alu_zero = z; fetch_field = f;
    exp_addr = model(exp_addr, r, b, j, z, f);
    @(posedge clk);
    #1;
    check(req, imem_addr, exp_addr);
    check("R1", {30'd0, imem_addr[1:0]}, 32'd0);
  endtask

  function automatic string tag_of(input logic b, input logic j, input logic z);
    if (j)           return (b && z) ? "R7" : "R6";
    else if (b && z) return "R4";
    else if (b || z) return "R5";
    else             return "R3";
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R2: reset state, also with every select asserted
    step(1, 0, 0, 0, 26'd0, "R2");
    step(1, 1, 1, 1, 26'h3FF_FFFF, "R2");
    // R3: plain stepping
    step(0, 0, 0, 0, 26'h155, "R3");
    step(0, 0, 0, 0, 26'h0FFFF, "R3");
    // R5: only one branch condition
    step(0, 1, 0, 0, 26'h00010, "R5");
    step(0, 0, 0, 1, 26'h00010, "R5");
    // R4: taken branches, forward, zero-offset-minus-one, extremes
    step(0, 1, 0, 1, 26'h00005, "R4");
    step(0, 1, 0, 1, 26'h0FFFF, "R4");
    step(0, 1, 0, 1, 26'h07FFF, "R4");
    step(0, 1, 0, 1, 26'h08000, "R4");
    // R6 / R8: jump to the top of region 0, then jump from there
    step(0, 0, 1, 0, 26'h3FF_FFFF, "R6");
    check("R6", imem_addr, 32'h0FFF_FFFC);
    step(0, 0, 1, 0, 26'h123, "R8");
    check("R8", imem_addr, 32'h0000_048C);
    step(0, 0, 1, 0, 26'h3FF_FFFF, "R6");
    step(0, 0, 0, 0, 26'd0, "R3");
    check("R3", imem_addr, 32'h1000_0000);
    step(0, 0, 1, 0, 26'h5, "R6");
    check("R6", imem_addr, 32'h1000_0014);
    // R7: jump beats a taken branch
    step(0, 1, 1, 1, 26'h2AA_0004, "R7");
    // Wrap at both ends
    step(1, 0, 0, 0, 26'd0, "R2");
    step(0, 0, 1, 0, 26'd0, "R6");
    step(0, 1, 0, 1, 26'h0FFFE, "R4");
    check("R4", imem_addr, 32'hFFFF_FFFC);
    step(0, 0, 0, 0, 26'd0, "R3");
    check("R3", imem_addr, 32'h0000_0000);
    // Sweep over every select combination
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 300; k++) begin
        logic [25:0] f;
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        case (k)
          0: f = 26'h0000000;
          1: f = 26'h0007FFF;
          2: f = 26'h0008000;
          3: f = 26'h000FFFF;
          4: f = 26'h3FFFFFF;
          default: f = rng[25:0];
        endcase
        step(0, c[2], c[1], c[0], f, tag_of(c[2], c[1], c[0]));
      end
    end
    step(1, 0, 1, 0, 26'h1, "R2");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule